// File: doc/BRIEF.md
# Triggered Parallel Pattern Streamer

This block plays a stream of 32-bit words out onto a narrow parallel pin bus. A host pushes words into an internal eight-entry transmit queue through a valid/ready write port. The block keeps the bus at zero until a start trigger arrives. It then takes each queued word apart into byte-wide slices, starting with the lowest byte. Each slice goes onto the pins for a fixed number of divider ticks. Only the lower six bits of every slice are driven. The upper two bits are dropped.

The tick input is a clock enable from an outside integer or fractional divider, so the pattern rate is set by the divider setting. The trigger can be shared with other streamers so they all start on the same tick. The block uses up its trigger: once running, it ignores further triggers. After a disable it will not move again until it sees a new trigger.

When the block goes to fetch a word and the queue is empty, the pins keep their last value and a sticky underflow flag is raised. Streaming resumes at the first tick after new data arrives. Dropping enable zeroes the pins, discards the word that was partly sent and clears the flag. Words still in the queue are kept.

Top module: `pattern_streamer`

## Requirements
- R1: After reset, `pins_o` is 0, `underflow_o` is 0, `wr_ready_o` is 1 and `full_o` is 0. While no trigger has been accepted, `pins_o` stays 0 whatever ticks and queued data arrive.
- R2: A one-cycle `trigger_i` pulse while `enable_i` is 1 and the block is waiting is remembered, even when no tick comes with it. The block accepts it on the next tick, and the pins stay 0 on that tick. The first slice appears on the tick after acceptance.
- R3: The trigger is used up when accepted. A trigger while running has no effect on the output stream. A trigger while `enable_i` is 0 is ignored. After a disable, the block needs a new trigger before it produces any output.
- R4: Slice k of a word (k = 0..3) is word bits [8k+7:8k]. Slices go out in order k = 0, 1, 2, 3. `pins_o` equals bits [5:0] of the current slice, and bits 6 and 7 are discarded.
- R5: `pins_o` changes only on a clock edge where `tick_i` is 1, or when disabling. Each slice is held for exactly 4 ticks. Consecutive slices and consecutive words follow with no gap.
- R6: When the fourth slice of a word is done, the next queued word is fetched on the tick that outputs its first slice. No extra tick is spent on the fetch.
- R7: The queue holds 8 words. `full_o` is 1 exactly when 8 words are held, and `wr_ready_o` is the inverse of `full_o`. A write offered while full is dropped.
- R8: If the queue is empty when a fetch falls due, `pins_o` holds its last value and `underflow_o` becomes 1 and stays 1. On the first tick after a word arrives, that word's slice 0 is output.
- R9: With `enable_i` at 0, `pins_o` is 0 and `underflow_o` is 0 from the next clock edge. The partly sent word is discarded, and words still queued are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Block enable; low forces idle with zero output |
| tick_i | input | 1 | Clock enable from the rate divider |
| trigger_i | input | 1 | Start trigger pulse |
| wr_valid_i | input | 1 | Write request for the word queue |
| wr_data_i | input | 32 | Word to queue |
| wr_ready_o | output | 1 | Queue accepts a write this cycle |
| full_o | output | 1 | Queue holds 8 words |
| pins_o | output | 6 | Parallel output bus |
| underflow_o | output | 1 | Sticky flag: a fetch found the queue empty |

## Verification
The bench sweeps tick spacings of one to three clocks across a full queue of words whose bytes set bits 6 and 7. A streamer that sent the high byte first or failed to mask the pins would then show the wrong value on the first slice. A trigger arriving between ticks is checked, and a design that needs trigger and tick together would stay at zero. A ninth write on a full queue must be dropped, so a queue that overwrites or grows would underflow late or play the wrong word. The bench also stalls on an empty queue, disables in the middle of a word and re-triggers. Any design that keeps shifting the old word, clears the sticky flag, or restarts without a new trigger shows a wrong pin value.

// File: rtl/pstream_pkg.sv
package pstream_pkg;

    localparam int unsigned DEF_WORD_W = 32;
    localparam int unsigned DEF_SLICE_W = 8;
    localparam int unsigned DEF_PIN_W = 6;
    localparam int unsigned DEF_DEPTH = 8;
    localparam int unsigned DEF_TICKS = 4;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_RUN  = 1'b1
    } strm_state_e;

    typedef struct packed {
        logic pend;
        strm_state_e state;
    } trig_ctl_t;

endpackage

// File: rtl/pstream_fifo.sv
module pstream_fifo #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid_i,
    input  logic [WIDTH-1:0] wr_data_i,
    output logic             wr_ready_o,
    output logic             full_o,
    input  logic             pop_i,
    output logic             empty_o,
    output logic [WIDTH-1:0] rd_data_o
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push, pop;

    assign full_o     = (count == CNT_W'(DEPTH));
    assign empty_o    = (count == '0);
    assign wr_ready_o = !full_o;
    assign push       = wr_valid_i && !full_o;
    assign pop        = pop_i && !empty_o;
    assign rd_data_o  = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assert_full_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (full_o && wr_valid_i && !pop_i) |=> (count == $past(count)));
    assert_bound_R7: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

endmodule

// File: rtl/pstream_cadence.sv
module pstream_cadence #(
    parameter int unsigned TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic tick_i,
    input  logic stall_i,
    output logic slot_o
);
    localparam int unsigned PH_W = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [PH_W-1:0] phase;
    logic            at_start;

    assign at_start = (phase == '0);
    assign slot_o   = run_i && tick_i && at_start;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            phase <= '0;
        end else if (tick_i && !(at_start && stall_i)) begin
            phase <= (phase == PH_W'(TICKS - 1)) ? '0 : phase + PH_W'(1);
        end
    end

    assert_phase_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase)) |-> ($past(tick_i) || !$past(run_i)));

endmodule

// File: rtl/pstream_unpacker.sv
module pstream_unpacker #(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned SLICE_W = 8,
    parameter int unsigned PIN_W   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_i,
    input  logic              slot_i,
    input  logic              empty_i,
    input  logic [WORD_W-1:0] data_i,
    output logic              pop_o,
    output logic              stall_o,
    output logic [PIN_W-1:0]  pins_o,
    output logic              underflow_o
);
    localparam int unsigned SLICES = WORD_W / SLICE_W;
    localparam int unsigned SL_W   = $clog2(SLICES + 1);

    logic [WORD_W-1:0] shreg;
    logic [SL_W-1:0]   left;
    logic              need_fetch;

    assign need_fetch = (left == '0);
    assign stall_o    = need_fetch && empty_i;
    assign pop_o      = slot_i && need_fetch && !empty_i && !flush_i;

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            shreg       <= '0;
            left        <= '0;
            pins_o      <= '0;
            underflow_o <= 1'b0;
        end else if (slot_i) begin
            if (need_fetch) begin
                if (empty_i) begin
                    underflow_o <= 1'b1;
                end else begin
                    pins_o <= data_i[PIN_W-1:0];
                    shreg  <= data_i >> SLICE_W;
                    left   <= SL_W'(SLICES - 1);
                end
            end else begin
                pins_o <= shreg[PIN_W-1:0];
                shreg  <= shreg >> SLICE_W;
                left   <= left - SL_W'(1);
            end
        end
    end

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (underflow_o && !flush_i) |=> underflow_o);
    assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (pins_o == '0 && !underflow_o));
    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (rst)
        (slot_i && stall_o && !flush_i) |=> $stable(pins_o));

endmodule

// File: rtl/pattern_streamer.sv
module pattern_streamer
    import pstream_pkg::*;
#(
    parameter int unsigned WORD_W  = DEF_WORD_W,
    parameter int unsigned SLICE_W = DEF_SLICE_W,
    parameter int unsigned PIN_W   = DEF_PIN_W,
    parameter int unsigned DEPTH   = DEF_DEPTH,
    parameter int unsigned TICKS   = DEF_TICKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              tick_i,
    input  logic              trigger_i,
    input  logic              wr_valid_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic              wr_ready_o,
    output logic              full_o,
    output logic [PIN_W-1:0]  pins_o,
    output logic              underflow_o
);
    trig_ctl_t         ctl;
    logic              run, slot, stall, pop, empty;
    logic [WORD_W-1:0] rd_data;

    assign run = (ctl.state == ST_RUN) && enable_i;

    always_ff @(posedge clk) begin
        if (rst || !enable_i) begin
            ctl.state <= ST_WAIT;
            ctl.pend  <= 1'b0;
        end else if (ctl.state == ST_WAIT) begin
            if (tick_i && (trigger_i || ctl.pend)) begin
                ctl.state <= ST_RUN;
                ctl.pend  <= 1'b0;
            end else if (trigger_i) begin
                ctl.pend <= 1'b1;
            end
        end
    end

    pstream_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .wr_valid_i (wr_valid_i),
        .wr_data_i  (wr_data_i),
        .wr_ready_o (wr_ready_o),
        .full_o     (full_o),
        .pop_i      (pop),
        .empty_o    (empty),
        .rd_data_o  (rd_data)
    );

    pstream_cadence #(.TICKS(TICKS)) u_cadence (
        .clk     (clk),
        .rst     (rst),
        .run_i   (run),
        .tick_i  (tick_i),
        .stall_i (stall),
        .slot_o  (slot)
    );

    pstream_unpacker #(.WORD_W(WORD_W), .SLICE_W(SLICE_W), .PIN_W(PIN_W)) u_unpack (
        .clk         (clk),
        .rst         (rst),
        .flush_i     (!enable_i),
        .slot_i      (slot),
        .empty_i     (empty),
        .data_i      (rd_data),
        .pop_o       (pop),
        .stall_o     (stall),
        .pins_o      (pins_o),
        .underflow_o (underflow_o)
    );

    assert_wait_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (ctl.state == ST_WAIT) |-> (pins_o == '0));
    assert_stay_running_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl.state == ST_RUN && enable_i) |=> (ctl.state == ST_RUN));
    assert_pins_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
        (pins_o != $past(pins_o)) |-> ($past(tick_i) || !$past(enable_i)));

endmodule

// File: tb/pattern_streamer_test.sv
module pattern_streamer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable_i = 1'b0;
    logic        tick_i = 1'b0;
    logic        trigger_i = 1'b0;
    logic        wr_valid_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        wr_ready_o, full_o, underflow_o;
    logic [5:0]  pins_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pattern_streamer uut (
        .clk(clk), .rst(rst), .enable_i(enable_i), .tick_i(tick_i),
        .trigger_i(trigger_i), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
        .wr_ready_o(wr_ready_o), .full_o(full_o), .pins_o(pins_o),
        .underflow_o(underflow_o)
    );

    function automatic logic [31:0] wgen(input int i);
        return 32'hC5E3_8FD1 ^ (32'(i) * 32'h0B1D_4E27);
    endfunction

    function automatic logic [31:0] exp_slice(input logic [31:0] w, input int k);
        return (w >> (8 * k)) & 32'h3F;
    endfunction

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_tick(input int div);
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
        repeat (div - 1) @(negedge clk);
    endtask

    task automatic pulse_trigger();
        @(negedge clk) trigger_i = 1'b1;
        @(negedge clk) trigger_i = 1'b0;
    endtask

    task automatic push(input logic [31:0] w, input bit expect_ok);
        @(negedge clk);
        check_eq("R7 ready before write", 32'(wr_ready_o), 32'(expect_ok));
        wr_valid_i = 1'b1;
        wr_data_i  = w;
        @(negedge clk);
        wr_valid_i = 1'b0;
    endtask

    task automatic play_word(input logic [31:0] w, input int div, input bit mid_trig);
        for (int k = 0; k < 4; k++) begin
            do_tick(div);
            check_eq("R4/R6 slice value", 32'(pins_o), exp_slice(w, k));
            if (mid_trig && k == 1) pulse_trigger();
            for (int t = 0; t < 3; t++) begin
                do_tick(div);
                check_eq("R5 slice held", 32'(pins_o), exp_slice(w, k));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1..: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 reset pins", 32'(pins_o), 0);
        check_eq("R1 reset underflow", 32'(underflow_o), 0);
        check_eq("R1 reset ready", 32'(wr_ready_o), 1);
        check_eq("R1 reset full", 32'(full_o), 0);

        enable_i = 1'b1;
        for (int i = 0; i < 8; i++) push(wgen(i), 1'b1);
        check_eq("R7 full at 8", 32'(full_o), 1);
        push(32'hDEAD_BEEF, 1'b0);
        check_eq("R7 still full", 32'(full_o), 1);

        for (int t = 0; t < 6; t++) begin
            do_tick(2);
            check_eq("R1 no output before trigger", 32'(pins_o), 0);
        end

        pulse_trigger();
        repeat (2) @(negedge clk);
        check_eq("R2 pending trigger pins zero", 32'(pins_o), 0);
        do_tick(1);
        check_eq("R2 accept tick pins zero", 32'(pins_o), 0);

        for (int i = 0; i < 8; i++) play_word(wgen(i), 1 + (i % 3), i == 2);

        do_tick(1);
        check_eq("R8 underflow set", 32'(underflow_o), 1);
        check_eq("R8 pins hold", 32'(pins_o), exp_slice(wgen(7), 3));
        do_tick(2);
        check_eq("R8 pins hold again", 32'(pins_o), exp_slice(wgen(7), 3));

        push(wgen(8), 1'b1);
        check_eq("R8 hold until tick", 32'(pins_o), exp_slice(wgen(7), 3));
        do_tick(1);
        check_eq("R8 resume slice0", 32'(pins_o), exp_slice(wgen(8), 0));
        check_eq("R8 sticky", 32'(underflow_o), 1);
        for (int t = 0; t < 3; t++) do_tick(1);
        do_tick(1);
        check_eq("R4 resume slice1", 32'(pins_o), exp_slice(wgen(8), 1));
        for (int t = 0; t < 3; t++) do_tick(1);

        push(wgen(9), 1'b1);
        @(negedge clk) enable_i = 1'b0;
        @(negedge clk);
        check_eq("R9 disable pins", 32'(pins_o), 0);
        check_eq("R9 disable underflow", 32'(underflow_o), 0);
        enable_i = 1'b1;
        for (int t = 0; t < 5; t++) begin
            do_tick(1);
            check_eq("R3 needs new trigger", 32'(pins_o), 0);
        end
        pulse_trigger();
        do_tick(1);
        check_eq("R2 accept after re-enable", 32'(pins_o), 0);
        do_tick(1);
        check_eq("R9 flushed word skipped", 32'(pins_o), exp_slice(wgen(9), 0));

        @(negedge clk) enable_i = 1'b0;
        pulse_trigger();
        @(negedge clk) enable_i = 1'b1;
        for (int t = 0; t < 4; t++) begin
            do_tick(1);
            check_eq("R3 trigger while disabled ignored", 32'(pins_o), 0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule